// File: doc/BRIEF.md
# Directory Home Controller for MSI Coherence

This block is the home node of a slice of a statically partitioned physical address space. For each cache line it owns, it keeps a directory entry with three fields: the line state (invalid, shared or modified), the identifier of the processor holding a dirty copy, and a bit vector of the processors holding clean copies. Processors send read and write requests only to this home. The home then sends coherence events only to the caches that must act on them. It never broadcasts.

A request is served directly from the built-in backing memory when no other cache must act. This is the two-hop case. Otherwise the home forwards a read event or a write event to the owner, or to each other sharer. It gathers their responses and only then completes the transaction. This is the three-hop case. A forwarded read causes the owner to hand its data to the requester and write it back to the home. A forwarded write causes the holder to invalidate its copy, and a former owner returns its dirty data to the home, which passes that data on in the grant. The controller works on one transaction at a time. New requests are stalled at the request port until the current transaction closes.

Top module: `homedir`

## Requirements
- R1: After reset, `reqReady` is high, `msgValid` is low, every line is invalid, and the memory word of line i holds the value i + 256.
- R2: A read to an invalid or shared line gets a grant-shared message (`msgKind` 3) to the requester, carrying the memory word, with `msgPeer` equal to the requester. There is no message in the cycle after the accepting edge, and the grant is valid in the cycle after that. The requester is added to the sharer vector.
- R3: A write to an invalid line, or to a shared line whose only sharer is the requester, gets a grant-modified message (`msgKind` 4) carrying the memory word, with the same timing as R2 and with no forwarded event.
- R4: A write to a shared line with other sharers sends one write event (`msgKind` 2, data zero) to each other sharer. It sends one per cycle, in ascending processor id. It sends none to the requester and none to a processor that holds no copy.
- R5: The grant for a forwarded transaction is sent only after every targeted processor has responded. A response from a processor that is not awaited, or that has already responded, is ignored.
- R6: A read to a modified line owned by another processor sends a read event (`msgKind` 1, data zero) to the owner, with `msgPeer` set to the requester. The owner's response data is written to memory. The line becomes shared by the owner and the requester. The home sends no message to the requester.
- R7: A write to a modified line owned by another processor sends a write event to the owner. After the owner responds, the home sends a grant-modified message to the requester carrying the owner's response data, and the requester becomes the owner.
- R8: A read or write from the current owner of a modified line gets an already-owner message (`msgKind` 5). No event is forwarded and the entry is left unchanged.
- R9: `reqReady` drops in the cycle after a request is accepted and stays low until the cycle of the transaction's final message. A request held while the controller is busy is accepted after that.
- R10: Directory entries are kept per line. A transaction on one line leaves the state, owner, sharers and memory of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqSrc | input | ID_W | Requesting processor |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqLine | input | LINE_W | Line index |
| rspValid | input | 1 | Response from a processor present |
| rspSrc | input | ID_W | Responding processor |
| rspData | input | DATA_W | Data carried by the response |
| msgValid | output | 1 | Outgoing message valid, one per cycle |
| msgKind | output | 3 | 1 read event, 2 write event, 3 grant shared, 4 grant modified, 5 already owner |
| msgDest | output | ID_W | Destination processor |
| msgLine | output | LINE_W | Line of the message |
| msgPeer | output | ID_W | Requester of the transaction |
| msgData | output | DATA_W | Line data for grants, zero for events |

## Verification
Two functions can meet in the same cycle: gathering acknowledgements and issuing the grant, and the request port accepting the next request. The bench holds a second request at the port while a multi-sharer invalidation is still waiting for acknowledgements. It also sends unrelated responses while the invalidation waits. It then checks that no grant leaves before the last real acknowledgement. It checks that the grant of the first transaction is followed in the next transaction by a correct grant for the held request, and that the held request was not accepted early.

// File: rtl/homedir_pkg.sv
package homedir_pkg;

  typedef enum logic [2:0] {
    MK_NONE          = 3'd0,
    MK_FWD_READ      = 3'd1,
    MK_FWD_WRITE     = 3'd2,
    MK_GRANT_SHARED  = 3'd3,
    MK_GRANT_MOD     = 3'd4,
    MK_ALREADY_OWNER = 3'd5
  } msg_kind_e;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic startFwd;
    logic sendNext;
    logic takeRsp;
    logic finRead;
    logic finWrite;
    logic finOwned;
    logic finWb;
  } dir_ctl_t;

endpackage

// File: rtl/homedir_dp.sv
module homedir_dp
  import homedir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int ID_W   = $clog2(N_PROC),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dir_ctl_t          ctl,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              rspValid,
  input  logic [ID_W-1:0]   rspSrc,
  input  logic [DATA_W-1:0] rspData,
  output logic              curWrite,
  output logic              stateMod,
  output logic              ownerIsReq,
  output logic              targetsEmpty,
  output logic              sendLast,
  output logic              rspHit,
  output logic              pendLast,
  output logic              pendEmpty,
  output logic              msgValid,
  output logic [2:0]        msgKind,
  output logic [ID_W-1:0]   msgDest,
  output logic [LINE_W-1:0] msgLine,
  output logic [ID_W-1:0]   msgPeer,
  output logic [DATA_W-1:0] msgData
);

  line_state_e       lineState   [LINES];
  logic [ID_W-1:0]   lineOwner   [LINES];
  logic [N_PROC-1:0] lineSharers [LINES];
  logic [DATA_W-1:0] memWord     [LINES];

  logic [ID_W-1:0]   curSrc;
  logic [LINE_W-1:0] curLine;
  logic [N_PROC-1:0] sendMask, pendMask;
  logic              fwdWrite, useOwnerData;
  logic [DATA_W-1:0] capData;

  line_state_e       eState;
  logic [ID_W-1:0]   eOwner;
  logic [N_PROC-1:0] eSharers, reqBit, ownerBit, rspBit, targets;
  logic [ID_W-1:0]   sendIdx;

  function automatic logic [ID_W-1:0] lowIdx(input logic [N_PROC-1:0] m);
    lowIdx = '0;
    for (int i = N_PROC - 1; i >= 0; i--)
      if (m[i]) lowIdx = ID_W'(i);
  endfunction

  always_comb begin
    eState   = lineState[curLine];
    eOwner   = lineOwner[curLine];
    eSharers = lineSharers[curLine];
    reqBit   = N_PROC'(1) << curSrc;
    ownerBit = N_PROC'(1) << eOwner;
    rspBit   = N_PROC'(1) << rspSrc;
    targets  = (eState == LS_MOD) ? ownerBit : (eSharers & ~reqBit);
    sendIdx  = lowIdx(sendMask);
  end

  assign stateMod     = (eState == LS_MOD);
  assign ownerIsReq   = (eOwner == curSrc);
  assign targetsEmpty = (targets == '0);
  assign sendLast     = ((sendMask & (sendMask - N_PROC'(1))) == '0);
  assign rspHit       = rspValid && ((pendMask & rspBit) != '0);
  assign pendLast     = rspHit && ((pendMask & ~rspBit) == '0);
  assign pendEmpty    = (pendMask == '0);

  // directory entries and backing memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        lineState[i]   <= LS_INV;
        lineOwner[i]   <= '0;
        lineSharers[i] <= '0;
        memWord[i]     <= DATA_W'(i + 256);
      end
    end else begin
      if (ctl.finRead) begin
        lineState[curLine]   <= LS_SHR;
        lineSharers[curLine] <= eSharers | reqBit;
      end
      if (ctl.finWrite) begin
        lineState[curLine]   <= LS_MOD;
        lineOwner[curLine]   <= curSrc;
        lineSharers[curLine] <= '0;
      end
      if (ctl.finWb) begin
        lineState[curLine]   <= LS_SHR;
        lineSharers[curLine] <= ownerBit | reqBit;
        memWord[curLine]     <= capData;
      end
    end
  end

  // transaction context
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc       <= '0;
      curLine      <= '0;
      curWrite     <= 1'b0;
      sendMask     <= '0;
      pendMask     <= '0;
      fwdWrite     <= 1'b0;
      useOwnerData <= 1'b0;
      capData      <= '0;
    end else begin
      if (ctl.latchReq) begin
        curSrc       <= reqSrc;
        curLine      <= reqLine;
        curWrite     <= reqWrite;
        useOwnerData <= 1'b0;
      end
      if (ctl.startFwd) begin
        sendMask     <= targets;
        pendMask     <= targets;
        fwdWrite     <= curWrite;
        useOwnerData <= (eState == LS_MOD);
      end else begin
        if (ctl.sendNext) sendMask <= sendMask & ~(N_PROC'(1) << sendIdx);
        if (ctl.takeRsp) begin
          pendMask <= pendMask & ~rspBit;
          capData  <= rspData;
        end
      end
    end
  end

  // registered outgoing message
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgKind  <= MK_NONE;
      msgDest  <= '0;
      msgLine  <= '0;
      msgPeer  <= '0;
      msgData  <= '0;
    end else begin
      msgValid <= ctl.sendNext | ctl.finRead | ctl.finWrite | ctl.finOwned;
      msgLine  <= curLine;
      msgPeer  <= curSrc;
      msgDest  <= curSrc;
      msgData  <= '0;
      msgKind  <= MK_NONE;
      if (ctl.sendNext) begin
        msgDest <= sendIdx;
        msgKind <= fwdWrite ? MK_FWD_WRITE : MK_FWD_READ;
      end else if (ctl.finRead) begin
        msgKind <= MK_GRANT_SHARED;
        msgData <= memWord[curLine];
      end else if (ctl.finWrite) begin
        msgKind <= MK_GRANT_MOD;
        msgData <= useOwnerData ? capData : memWord[curLine];
      end else if (ctl.finOwned) begin
        msgKind <= MK_ALREADY_OWNER;
      end
    end
  end

endmodule

// File: rtl/homedir_ctl.sv
module homedir_ctl
  import homedir_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  input  logic     curWrite,
  input  logic     stateMod,
  input  logic     ownerIsReq,
  input  logic     targetsEmpty,
  input  logic     sendLast,
  input  logic     rspHit,
  input  logic     pendLast,
  input  logic     pendEmpty,
  output dir_ctl_t ctl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_SEND, ST_WAIT, ST_FIN
  } ctl_state_e;

  ctl_state_e state, nextState;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        ctl.latchReq = reqValid;
        if (reqValid) nextState = ST_EVAL;
      end
      ST_EVAL: begin
        nextState = ST_IDLE;
        if (stateMod && ownerIsReq)               ctl.finOwned = 1'b1;
        else if (!curWrite && !stateMod)          ctl.finRead  = 1'b1;
        else if (curWrite && !stateMod && targetsEmpty) ctl.finWrite = 1'b1;
        else begin
          ctl.startFwd = 1'b1;
          nextState    = ST_SEND;
        end
      end
      ST_SEND: begin
        ctl.sendNext = 1'b1;
        ctl.takeRsp  = rspHit;
        if (sendLast) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        ctl.takeRsp = rspHit;
        if (pendEmpty || pendLast) nextState = ST_FIN;
      end
      ST_FIN: begin
        if (curWrite) ctl.finWrite = 1'b1;
        else          ctl.finWb    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/homedir.sv
module homedir
  import homedir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int ID_W   = $clog2(N_PROC),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              rspValid,
  input  logic [ID_W-1:0]   rspSrc,
  input  logic [DATA_W-1:0] rspData,
  output logic              msgValid,
  output logic [2:0]        msgKind,
  output logic [ID_W-1:0]   msgDest,
  output logic [LINE_W-1:0] msgLine,
  output logic [ID_W-1:0]   msgPeer,
  output logic [DATA_W-1:0] msgData
);

  dir_ctl_t ctl;
  logic curWrite, stateMod, ownerIsReq, targetsEmpty;
  logic sendLast, rspHit, pendLast, pendEmpty;

  homedir_ctl u_ctl (
    .clk, .rstN, .reqValid, .reqReady,
    .curWrite, .stateMod, .ownerIsReq, .targetsEmpty,
    .sendLast, .rspHit, .pendLast, .pendEmpty, .ctl
  );

  homedir_dp #(.N_PROC(N_PROC), .LINES(LINES), .DATA_W(DATA_W)) u_dp (
    .clk, .rstN, .ctl, .reqSrc, .reqWrite, .reqLine,
    .rspValid, .rspSrc, .rspData,
    .curWrite, .stateMod, .ownerIsReq, .targetsEmpty,
    .sendLast, .rspHit, .pendLast, .pendEmpty,
    .msgValid, .msgKind, .msgDest, .msgLine, .msgPeer, .msgData
  );

endmodule

// File: rtl/homedir_chk.sv
module homedir_chk #(
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            msgValid,
  input logic [2:0]      msgKind,
  input logic [ID_W-1:0] msgDest,
  input logic [ID_W-1:0] msgPeer
);

  logic isFwd, isGrant;
  assign isFwd   = (msgKind == 3'd1) || (msgKind == 3'd2);
  assign isGrant = (msgKind == 3'd3) || (msgKind == 3'd4) || (msgKind == 3'd5);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_quiet_eval_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !msgValid);

  p_fwd_skips_requester_r4: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && isFwd) |-> (msgDest != msgPeer));

  p_grant_to_requester_r2: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && isGrant) |-> (msgDest == msgPeer));

  p_grant_closes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && isGrant) |-> reqReady);

  p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (isFwd || isGrant));

endmodule

bind homedir homedir_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .msgValid(msgValid), .msgKind(msgKind), .msgDest(msgDest), .msgPeer(msgPeer)
);

// File: tb/homedir_bench.sv
module homedir_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [1:0]  reqSrc = '0;
  logic [3:0]  reqLine = '0;
  logic        rspValid = 1'b0;
  logic [1:0]  rspSrc = '0;
  logic [31:0] rspData = '0;
  logic        msgValid;
  logic [2:0]  msgKind;
  logic [1:0]  msgDest, msgPeer;
  logic [3:0]  msgLine;
  logic [31:0] msgData;

  homedir u_homedir (
    .clk, .rstN, .reqValid, .reqReady, .reqSrc, .reqWrite, .reqLine,
    .rspValid, .rspSrc, .rspData,
    .msgValid, .msgKind, .msgDest, .msgLine, .msgPeer, .msgData
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  dest;
    logic [2:0]  kind;
    logic [3:0]  line;
    logic [31:0] data;
    logic [1:0]  peer;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int checks = 0, bad = 0, seenMsgs = 0;

  task automatic expectMsg(string tag, int dest, int kind, int line, int data, int peer);
    exp_t e;
    e.dest = 2'(dest); e.kind = 3'(kind); e.line = 4'(line);
    e.data = 32'(data); e.peer = 2'(peer);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic check(string tag, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected messages as the design emits them
  always @(negedge clk) begin
    if (rstN && msgValid) begin
      exp_t  e;
      exp_t  got;
      string t;
      seenMsgs++;
      checks++;
      got = {msgDest, msgKind, msgLine, msgData, msgPeer};
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL unexpected message actual=%0h expected=none (R6/R5)", got);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (got !== e) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", t, got, e);
        end
      end
    end
  end

  task automatic sendReq(int src, bit wr, int line);
    @(negedge clk);
    reqValid = 1'b1; reqSrc = 2'(src); reqWrite = wr; reqLine = 4'(line);
    forever begin
      if (reqReady) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 reqValid = 1'b0;
  endtask

  task automatic sendRsp(int src, int data);
    @(negedge clk);
    rspValid = 1'b1; rspSrc = 2'(src); rspData = 32'(data);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic waitQueue();
    while (expQ.size() != 0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic waitIdle();
    waitQueue();
    while (!reqReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", reqReady === 1'b1, reqReady, 1);
    check("R1 idle", msgValid === 1'b0, msgValid, 0);

    // R2: read of invalid line, timing and data
    expectMsg("R2 read I", 0, 3, 3, 32'h103, 0);
    sendReq(0, 0, 3);
    @(negedge clk);
    check("R2 no msg first cycle", msgValid === 1'b0, msgValid, 0);
    @(negedge clk);
    check("R2 grant second cycle", msgValid === 1'b1, msgValid, 1);
    waitIdle();
    expectMsg("R2 read S", 1, 3, 3, 32'h103, 1);
    sendReq(1, 0, 3);
    waitIdle();
    expectMsg("R2 read S", 2, 3, 3, 32'h103, 2);
    sendReq(2, 0, 3);
    waitIdle();

    // R4/R5/R9: write to S with sharers {0,1,2} from P1, plus held request
    base = seenMsgs;
    expectMsg("R4 inval first", 0, 2, 3, 0, 1);
    expectMsg("R4 inval second", 2, 2, 3, 0, 1);
    sendReq(1, 1, 3);
    repeat (5) @(negedge clk);
    check("R4 two events only", (seenMsgs - base) == 2, seenMsgs - base, 2);
    check("R9 busy", reqReady === 1'b0, reqReady, 0);
    reqValid = 1'b1; reqSrc = 2'd3; reqWrite = 1'b0; reqLine = 4'd5;
    sendRsp(3, 32'h55);
    sendRsp(1, 32'h66);
    repeat (3) @(negedge clk);
    check("R5 stray ignored", (seenMsgs - base) == 2, seenMsgs - base, 2);
    sendRsp(2, 0);
    sendRsp(2, 0);
    repeat (3) @(negedge clk);
    check("R5 one ack missing", (seenMsgs - base) == 2, seenMsgs - base, 2);
    check("R9 held not accepted", reqReady === 1'b0, reqReady, 0);
    expectMsg("R5 grant after acks", 1, 4, 3, 32'h103, 1);
    expectMsg("R9 held request", 3, 3, 5, 32'h105, 3);
    sendRsp(0, 0);
    forever begin
      @(negedge clk);
      if (reqReady) begin
        @(posedge clk);
        break;
      end
    end
    #1 reqValid = 1'b0;
    waitIdle();

    // R8: owner requests again
    expectMsg("R8 owner write", 1, 5, 3, 0, 1);
    sendReq(1, 1, 3);
    waitIdle();
    expectMsg("R8 owner read", 1, 5, 3, 0, 1);
    sendReq(1, 0, 3);
    waitIdle();

    // R6: read of modified line owned by P1
    expectMsg("R6 fwd read", 1, 1, 3, 0, 2);
    sendReq(2, 0, 3);
    waitQueue();
    sendRsp(1, 32'hDEAD0001);
    repeat (3) @(negedge clk);
    check("R6 home silent", expQ.size() == 0, expQ.size(), 0);
    expectMsg("R6 memory updated", 3, 3, 3, 32'hDEAD0001, 3);
    sendReq(3, 0, 3);
    waitIdle();

    // R4: sharers now {1,2,3}, write by P0
    expectMsg("R4 inval 1", 1, 2, 3, 0, 0);
    expectMsg("R4 inval 2", 2, 2, 3, 0, 0);
    expectMsg("R4 inval 3", 3, 2, 3, 0, 0);
    sendReq(0, 1, 3);
    waitQueue();
    sendRsp(3, 0);
    sendRsp(1, 0);
    expectMsg("R5 grant three acks", 0, 4, 3, 32'hDEAD0001, 0);
    sendRsp(2, 0);
    waitIdle();

    // R7: write of modified line owned by P0
    expectMsg("R7 fwd write", 0, 2, 3, 0, 2);
    sendReq(2, 1, 3);
    waitQueue();
    expectMsg("R7 owner data", 2, 4, 3, 32'hBEEF0002, 2);
    sendRsp(0, 32'hBEEF0002);
    waitIdle();
    expectMsg("R8 new owner", 2, 5, 3, 0, 2);
    sendReq(2, 1, 3);
    waitIdle();

    // R3: write to invalid line, timing
    expectMsg("R3 write I", 3, 4, 7, 32'h107, 3);
    sendReq(3, 1, 7);
    @(negedge clk);
    check("R3 no msg first cycle", msgValid === 1'b0, msgValid, 0);
    @(negedge clk);
    check("R3 grant second cycle", msgValid === 1'b1, msgValid, 1);
    waitIdle();
    expectMsg("R3 read sole", 0, 3, 9, 32'h109, 0);
    sendReq(0, 0, 9);
    waitIdle();
    expectMsg("R3 write sole sharer", 0, 4, 9, 32'h109, 0);
    sendReq(0, 1, 9);
    waitIdle();

    // R10: line 5 kept sharer {3} through all line 3 traffic
    expectMsg("R10 line5 inval", 3, 2, 5, 0, 0);
    sendReq(0, 1, 5);
    waitQueue();
    expectMsg("R10 line5 grant", 0, 4, 5, 32'h105, 0);
    sendRsp(3, 0);
    waitIdle();

    check("R5 queue drained", expQ.size() == 0, expQ.size(), 0);
    summary();
    $finish;
  end
endmodule